// File: doc/BRIEF.md
# Lane-Batched Shared Tail Reservation

This block lets a group of SIMD lanes claim space at the tail of a shared queue with a single atomic update, instead of one atomic per lane. When a request is accepted, each lane states how many elements it wants, and a mask says which lanes take part. The block adds up those counts across the lanes. It names the most significant active lane as the one lane that stands for the group. It then reads the shared tail once, through a memory-side port. After that it issues compare-and-swap operations on the tail until one of them succeeds.

The tail value that the successful swap replaced becomes the base of the reservation. That base goes out to every active lane. Each lane's slot index is the base plus the sum of the counts of the active lanes below it. A group of up to the lane count of producers therefore costs one read and one successful swap on the shared pointer, plus one more swap for every time another producer moved the tail in between. Wrap-around, overflow and the queue storage are handled elsewhere.

The memory side is a read handshake and a compare-and-swap handshake, both request/acknowledge. Every compare-and-swap acknowledge returns the value that was in the tail before the operation.

Top module: `tail_batch_resv`

## Requirements
- R1: When a request is accepted, the leader is the highest-numbered lane whose mask bit is 1. Its index appears on `leader_idx` with `leader_valid` high. If the mask is all zero, `leader_valid` is low.
- R2: Lane i's offset is the sum of `lane_count` over the active lanes j < i. A lane whose mask bit is 0 adds nothing, whatever its count field holds. Lane i's count field is `lane_count[i*CNT_W +: CNT_W]`.
- R3: A successful batch moves the shared tail forward by exactly the total count of the active lanes. Every compare-and-swap proposes `cas_swap` equal to `cas_cmp` plus that total.
- R4: A batch with a nonzero total issues exactly one tail read. Its first compare-and-swap compares against the value that read returned. `tail_rd_req` and `cas_req` are never high together.
- R5: If a compare-and-swap returns a value different from its compare value, another compare-and-swap follows, using the returned value as the new compare value. This repeats until the returned value equals the compare value. That value is the batch base.
- R6: After a grant, `slot_valid[i]` is 1 exactly for the active lanes. The slot of an active lane, `slot_flat[i*TAIL_W +: TAIL_W]`, is the base plus its offset. Inactive lanes read slot 0.
- R7: A request whose active total is zero makes no tail access. `done` rises one cycle after acceptance, `busy` stays low, and `slot_valid` is all zero.
- R8: `done` is a single-cycle pulse. Slot, valid, leader and retry outputs hold until the next accepted request. A `start` while `busy` is high is ignored.
- R9: `retry_count` equals the number of failed compare-and-swaps in the latest batch. It is cleared when a request is accepted and saturates at its all-ones value.
- R10: With acknowledges that arrive in the cycle after each request, `done` rises 3 cycles after a nonzero request is accepted, plus one cycle for each failed compare-and-swap.
- R11: After reset, `busy`, `done`, `tail_rd_req`, `cas_req`, `slot_valid`, `leader_valid` and `retry_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a batch; accepted when not busy |
| lane_active | input | LANES | Lanes taking part in the batch |
| lane_count | input | LANES*CNT_W | Per-lane element counts, lane i at bits i*CNT_W |
| busy | output | 1 | A reservation with a nonzero total is in progress |
| done | output | 1 | One-cycle completion pulse |
| tail_rd_req | output | 1 | Read request for the shared tail |
| tail_rd_ack | input | 1 | Read acknowledge |
| tail_rd_data | input | TAIL_W | Tail value returned by the read |
| cas_req | output | 1 | Compare-and-swap request on the tail |
| cas_cmp | output | TAIL_W | Value the tail is expected to hold |
| cas_swap | output | TAIL_W | Value to write if the compare matches |
| cas_ack | input | 1 | Compare-and-swap acknowledge |
| cas_old | input | TAIL_W | Tail value before the operation |
| leader_valid | output | 1 | A leader lane exists for the latest request |
| leader_idx | output | $clog2(LANES) | Index of the leader lane |
| slot_valid | output | LANES | Lanes holding a granted slot |
| slot_flat | output | LANES*TAIL_W | Per-lane slot index, lane i at bits i*TAIL_W |
| retry_count | output | RETRY_W | Failed compare-and-swaps in the latest batch |

## Verification
The count patterns are chosen so that mistakes show up. Dense counts on every lane show whether the sum is inclusive or exclusive. A sparse mask with nonzero counts on masked-off lanes shows whether those counts leak into the sum. Zero counts on active lanes check that such lanes get a slot but add nothing. A lone bottom lane and a lone top lane check leader selection at both ends of the lane range.

Other producers are modelled by bumping the tail just before a swap is answered. With zero, one, several or a few hundred such bumps, the bench can tell a base taken from the first read apart from one taken from the last successful swap. The same runs exercise the retry count and its saturation. An all-zero total, an empty mask, and a second start sent while the block is busy check the shortcut path and the guard against accepting a new request.

// File: rtl/tail_resv_pkg.sv
package tail_resv_pkg;

    localparam int unsigned DEF_LANES   = 16;
    localparam int unsigned DEF_CNT_W   = 4;
    localparam int unsigned DEF_TAIL_W  = 16;
    localparam int unsigned DEF_RETRY_W = 8;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_READ = 2'd1,
        RS_SWAP = 2'd2
    } resv_state_e;

    // Width that holds the sum of `lanes` counts of `cw` bits each
    function automatic int unsigned sum_width(input int unsigned lanes, input int unsigned cw);
        return cw + $clog2(lanes);
    endfunction

endpackage

// File: rtl/resv_prefix.sv
module resv_prefix #(
    parameter int unsigned LANES = 16,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned SUM_W = 8
) (
    input  logic [LANES-1:0]       active,
    input  logic [LANES*CNT_W-1:0] counts,
    output logic [LANES*SUM_W-1:0] offsets,
    output logic [SUM_W-1:0]       total
);
    logic [SUM_W-1:0] acc [LANES+1];

    assign acc[0] = '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SUM_W-1:0] masked;
        assign masked = active[g] ? SUM_W'(counts[g*CNT_W +: CNT_W]) : '0;
        assign acc[g+1] = acc[g] + masked;
        assign offsets[g*SUM_W +: SUM_W] = acc[g];
    end

    assign total = acc[LANES];
endmodule

// File: rtl/resv_leader.sv
module resv_leader #(
    parameter int unsigned LANES = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [LANES-1:0] active,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (active[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/resv_cas_fsm.sv
module resv_cas_fsm
    import tail_resv_pkg::*;
#(
    parameter int unsigned TAIL_W  = 16,
    parameter int unsigned SUM_W   = 8,
    parameter int unsigned RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [SUM_W-1:0]   total_in,
    output logic               busy,
    output logic               done,
    output logic               granted,
    output logic [TAIL_W-1:0]  base,
    output logic [RETRY_W-1:0] retries,
    output logic               rd_req,
    input  logic               rd_ack,
    input  logic [TAIL_W-1:0]  rd_data,
    output logic               cas_req,
    output logic [TAIL_W-1:0]  cas_cmp,
    output logic [TAIL_W-1:0]  cas_swap,
    input  logic               cas_ack,
    input  logic [TAIL_W-1:0]  cas_old
);
    localparam logic [RETRY_W-1:0] RETRY_MAX = '1;

    resv_state_e       state;
    logic [SUM_W-1:0]  tot_q;
    logic [TAIL_W-1:0] seen_q;

    assign busy     = (state != RS_IDLE);
    assign rd_req   = (state == RS_READ);
    assign cas_req  = (state == RS_SWAP);
    assign cas_cmp  = seen_q;
    assign cas_swap = seen_q + TAIL_W'(tot_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RS_IDLE;
            tot_q   <= '0;
            seen_q  <= '0;
            base    <= '0;
            retries <= '0;
            done    <= 1'b0;
            granted <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                RS_IDLE: begin
                    if (go) begin
                        retries <= '0;
                        granted <= 1'b0;
                        tot_q   <= total_in;
                        if (total_in == '0) begin
                            done <= 1'b1;
                        end else begin
                            state <= RS_READ;
                        end
                    end
                end
                RS_READ: begin
                    if (rd_ack) begin
                        seen_q <= rd_data;
                        state  <= RS_SWAP;
                    end
                end
                RS_SWAP: begin
                    if (cas_ack) begin
                        if (cas_old == seen_q) begin
                            base    <= seen_q;
                            done    <= 1'b1;
                            granted <= 1'b1;
                            state   <= RS_IDLE;
                        end else begin
                            seen_q <= cas_old;
                            if (retries != RETRY_MAX) begin
                                retries <= retries + 1'b1;
                            end
                        end
                    end
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    // R4: the read and the swap never overlap
    p_port_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && cas_req));

    // R5: a failed swap is followed by a swap comparing against the returned value
    p_retry_cmp_r5: assert property (@(posedge clk) disable iff (rst)
        (cas_req && cas_ack && (cas_old != cas_cmp)) |=> (cas_req && cas_cmp == $past(cas_old)));

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: each failed swap advances the retry count below saturation
    p_retry_step_r9: assert property (@(posedge clk) disable iff (rst)
        (cas_req && cas_ack && (cas_old != cas_cmp) && retries != RETRY_MAX)
        |=> (retries == $past(retries) + 1'b1));
endmodule

// File: rtl/tail_batch_resv.sv
module tail_batch_resv
    import tail_resv_pkg::*;
#(
    parameter int unsigned LANES   = DEF_LANES,
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned TAIL_W  = DEF_TAIL_W,
    parameter int unsigned RETRY_W = DEF_RETRY_W,
    localparam int unsigned IDX_W  = $clog2(LANES),
    localparam int unsigned SUM_W  = sum_width(LANES, CNT_W)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [LANES-1:0]          lane_active,
    input  logic [LANES*CNT_W-1:0]    lane_count,
    output logic                      busy,
    output logic                      done,
    output logic                      tail_rd_req,
    input  logic                      tail_rd_ack,
    input  logic [TAIL_W-1:0]         tail_rd_data,
    output logic                      cas_req,
    output logic [TAIL_W-1:0]         cas_cmp,
    output logic [TAIL_W-1:0]         cas_swap,
    input  logic                      cas_ack,
    input  logic [TAIL_W-1:0]         cas_old,
    output logic                      leader_valid,
    output logic [IDX_W-1:0]          leader_idx,
    output logic [LANES-1:0]          slot_valid,
    output logic [LANES*TAIL_W-1:0]   slot_flat,
    output logic [RETRY_W-1:0]        retry_count
);
    logic [LANES*SUM_W-1:0] off_in;
    logic [SUM_W-1:0]       total_in;
    logic                   lead_found;
    logic [IDX_W-1:0]       lead_idx_in;
    logic                   accept;
    logic                   granted;
    logic [TAIL_W-1:0]      base;

    logic [LANES-1:0]       act_q;
    logic [LANES*SUM_W-1:0] off_q;

    assign accept = start && !busy;

    resv_prefix #(.LANES(LANES), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_prefix (
        .active  (lane_active),
        .counts  (lane_count),
        .offsets (off_in),
        .total   (total_in)
    );

    resv_leader #(.LANES(LANES), .IDX_W(IDX_W)) u_leader (
        .active (lane_active),
        .found  (lead_found),
        .idx    (lead_idx_in)
    );

    resv_cas_fsm #(.TAIL_W(TAIL_W), .SUM_W(SUM_W), .RETRY_W(RETRY_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .go       (accept),
        .total_in (total_in),
        .busy     (busy),
        .done     (done),
        .granted  (granted),
        .base     (base),
        .retries  (retry_count),
        .rd_req   (tail_rd_req),
        .rd_ack   (tail_rd_ack),
        .rd_data  (tail_rd_data),
        .cas_req  (cas_req),
        .cas_cmp  (cas_cmp),
        .cas_swap (cas_swap),
        .cas_ack  (cas_ack),
        .cas_old  (cas_old)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q        <= '0;
            off_q        <= '0;
            leader_valid <= 1'b0;
            leader_idx   <= '0;
        end else if (accept) begin
            act_q        <= lane_active;
            off_q        <= off_in;
            leader_valid <= lead_found;
            leader_idx   <= lead_idx_in;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_slot
        logic live;
        assign live = granted && act_q[g];
        assign slot_valid[g] = live;
        assign slot_flat[g*TAIL_W +: TAIL_W] =
            live ? (base + TAIL_W'(off_q[g*SUM_W +: SUM_W])) : '0;
    end

    // R1: the leader is an active lane with no active lane above it
    p_leader_msb_r1: assert property (@(posedge clk) disable iff (rst)
        leader_valid |-> ((act_q >> leader_idx) == LANES'(1)));

    // R7: a zero total completes next cycle without becoming busy or granting
    p_zero_short_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && total_in == '0) |=> (done && !busy && slot_valid == '0));

    // R8: a start while busy leaves the latched lane set unchanged
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(act_q));
endmodule

// File: tb/tail_batch_resv_test.sv
module tail_batch_resv_test;
    localparam int LANES = 16;
    localparam int CNT_W = 4;
    localparam int TAIL_W = 16;
    localparam int RETRY_W = 8;
    localparam int IDX_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LANES-1:0] lane_active = '0;
    logic [LANES*CNT_W-1:0] lane_count = '0;
    logic busy, done, tail_rd_req, cas_req, leader_valid;
    logic tail_rd_ack = 1'b0;
    logic cas_ack = 1'b0;
    logic [TAIL_W-1:0] tail_rd_data = '0;
    logic [TAIL_W-1:0] cas_old = '0;
    logic [TAIL_W-1:0] cas_cmp, cas_swap;
    logic [IDX_W-1:0] leader_idx;
    logic [LANES-1:0] slot_valid;
    logic [LANES*TAIL_W-1:0] slot_flat;
    logic [RETRY_W-1:0] retry_count;

    always #4 clk = ~clk;

    tail_batch_resv uut (
        .clk(clk), .rst(rst), .start(start),
        .lane_active(lane_active), .lane_count(lane_count),
        .busy(busy), .done(done),
        .tail_rd_req(tail_rd_req), .tail_rd_ack(tail_rd_ack), .tail_rd_data(tail_rd_data),
        .cas_req(cas_req), .cas_cmp(cas_cmp), .cas_swap(cas_swap),
        .cas_ack(cas_ack), .cas_old(cas_old),
        .leader_valid(leader_valid), .leader_idx(leader_idx),
        .slot_valid(slot_valid), .slot_flat(slot_flat), .retry_count(retry_count)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // shared-memory model state
    int tail_mem = 100;
    int rd_cnt = 0;
    int cas_cnt = 0;
    int steal_left = 0;
    int steal_amt = 0;
    int cur_total = 0;
    bit swap_bad = 0;

    int cnt_v [LANES];
    logic [LANES-1:0] msk_v;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory side: answers every request in the following cycle; other producers
    // bump the tail just before a swap is serviced.
    always @(negedge clk) begin
        tail_rd_ack = 1'b0;
        cas_ack = 1'b0;
        if (!rst && tail_rd_req) begin
            rd_cnt++;
            tail_rd_data = TAIL_W'(tail_mem);
            tail_rd_ack = 1'b1;
        end
        if (!rst && cas_req) begin
            cas_cnt++;
            if (int'(cas_swap) != ((int'(cas_cmp) + cur_total) % 65536)) swap_bad = 1;
            if (steal_left > 0) begin
                tail_mem = (tail_mem + steal_amt) % 65536;
                steal_left--;
            end
            cas_old = TAIL_W'(tail_mem);
            if (tail_mem == int'(cas_cmp)) tail_mem = int'(cas_swap);
            cas_ack = 1'b1;
        end
    end

    task automatic run_batch(input int steals, input int amt, input bit intrude, input string tag);
        int exp_off [LANES];
        int tot;
        int base_exp;
        int tail0;
        int k;
        bit seen;
        int exp_k;
        int exp_lead;
        logic [LANES*TAIL_W-1:0] slots_at_done;
        tot = 0;
        exp_lead = -1;
        for (int i = 0; i < LANES; i++) begin
            exp_off[i] = tot;
            if (msk_v[i]) begin
                tot += cnt_v[i];
                exp_lead = i;
            end
        end
        tail0 = tail_mem;
        rd_cnt = 0; cas_cnt = 0; swap_bad = 0;
        steal_left = steals; steal_amt = amt; cur_total = tot;
        base_exp = (tail0 + steals * amt) % 65536;
        exp_k = (tot == 0) ? 1 : 3 + steals;

        @(negedge clk);
        start = 1'b1;
        lane_active = msk_v;
        for (int i = 0; i < LANES; i++) lane_count[i*CNT_W +: CNT_W] = CNT_W'(cnt_v[i]);
        k = 0; seen = 0;
        while (!seen && k < 1000) begin
            @(negedge clk);
            k++;
            start = 1'b0;
            if (intrude && k == 2) begin
                start = 1'b1;
                lane_active = '1;
                lane_count = '1;
            end
            if (done) seen = 1;
        end
        start = 1'b0;
        slots_at_done = slot_flat;

        chk(seen && k == exp_k, {tag, " R10 latency"}, k, exp_k);
        chk(leader_valid == (exp_lead >= 0), {tag, " R1 leader_valid"}, leader_valid, exp_lead >= 0);
        if (exp_lead >= 0)
            chk(int'(leader_idx) == exp_lead, {tag, " R1 leader_idx"}, leader_idx, exp_lead);
        if (tot == 0) begin
            chk(slot_valid == '0, {tag, " R7 no grant"}, slot_valid, 0);
            chk(rd_cnt == 0 && cas_cnt == 0, {tag, " R7 no tail access"}, rd_cnt + cas_cnt, 0);
            chk(tail_mem == tail0, {tag, " R7 tail unchanged"}, tail_mem, tail0);
        end else begin
            chk(slot_valid == msk_v, {tag, " R6 slot_valid"}, slot_valid, msk_v);
            for (int i = 0; i < LANES; i++) begin
                int e;
                e = msk_v[i] ? (base_exp + exp_off[i]) % 65536 : 0;
                chk(int'(slot_flat[i*TAIL_W +: TAIL_W]) == e,
                    {tag, " R2/R6 slot"}, slot_flat[i*TAIL_W +: TAIL_W], e);
            end
            chk(tail_mem == (base_exp + tot) % 65536, {tag, " R3 tail advance"}, tail_mem, (base_exp + tot) % 65536);
            chk(!swap_bad, {tag, " R3 swap value"}, swap_bad, 0);
            chk(rd_cnt == 1, {tag, " R4 one read"}, rd_cnt, 1);
            chk(cas_cnt == steals + 1, {tag, " R5 swap count"}, cas_cnt, steals + 1);
        end
        chk(int'(retry_count) == ((steals > 255) ? 255 : steals), {tag, " R9 retries"},
            retry_count, (steals > 255) ? 255 : steals);
        @(negedge clk);
        chk(!done, {tag, " R8 done pulse"}, done, 0);
        @(negedge clk);
        chk(slot_flat == slots_at_done, {tag, " R8 hold"}, slot_flat == slots_at_done, 1);
        chk(!busy, {tag, " R8 idle after"}, busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !tail_rd_req && !cas_req, "R11 reset ctrl", {busy, done, tail_rd_req, cas_req}, 0);
        chk(slot_valid == '0 && !leader_valid && retry_count == '0, "R11 reset outputs",
            {slot_valid, leader_valid, retry_count}, 0);

        // dense: all lanes, counts 1..5
        msk_v = '1;
        for (int i = 0; i < LANES; i++) cnt_v[i] = (i % 5) + 1;
        run_batch(0, 0, 0, "dense");

        // sparse mask, masked-off lanes carry counts, zero counts on active lanes, contention
        msk_v = 16'b0101_1010_0011_0110;
        for (int i = 0; i < LANES; i++) cnt_v[i] = (i % 3 == 0) ? 0 : (i + 7) % 16;
        run_batch(2, 9, 0, "sparse");

        // all active, all zero counts
        msk_v = '1;
        for (int i = 0; i < LANES; i++) cnt_v[i] = 0;
        run_batch(0, 0, 0, "zero_total");

        // empty mask with nonzero counts
        msk_v = '0;
        for (int i = 0; i < LANES; i++) cnt_v[i] = 15;
        run_batch(0, 0, 0, "empty_mask");

        // only lane 0, max count
        msk_v = 16'h0001;
        for (int i = 0; i < LANES; i++) cnt_v[i] = 15;
        run_batch(1, 3, 0, "lane0");

        // only top lane, heavier contention
        msk_v = 16'h8000;
        for (int i = 0; i < LANES; i++) cnt_v[i] = 6;
        run_batch(3, 1, 0, "top_lane");

        // start while busy must be ignored
        msk_v = 16'h0F0F;
        for (int i = 0; i < LANES; i++) cnt_v[i] = 2;
        run_batch(3, 5, 1, "intrude");

        // retry saturation
        msk_v = 16'h00FF;
        for (int i = 0; i < LANES; i++) cnt_v[i] = 1;
        run_batch(260, 1, 0, "saturate");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule